// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches a free-running timer value supplied from outside and holds three compare values. The moment the timer first equals compare value 0, a chosen group of the six lower output bits is driven high. The moment it first equals compare value 1, a second chosen group of those bits is driven low, and the two upper output bits, which are toggle flip-flops, can be inverted. Compare value 2 drives no output. It only reports a match.

Every compare value has a sticky match flag. Two more sticky flags record the wrap of the timer's low byte and the wrap of the whole timer. A request vector presents these events to an interrupt controller. Match requests appear one cycle after their flags. Overflow requests appear together with their flags. Software loads the compare values and the two enable registers through a single write port. It can read back the set-enable bits together with the current state of the toggle flip-flops.

Top module: `cmp_out_unit`

## Requirements
- R1: When compare value 0 first matches the timer in cycle n, every output bit k (k in 0..5) whose set-enable bit k is 1 reads 1 from cycle n+1.
- R2: When compare value 1 first matches the timer in cycle n, every output bit k (k in 0..5) whose reset/toggle-enable bit k is 1 reads 0 from cycle n+1.
- R3: When compare value 1 first matches in cycle n, output bits 6 and 7 invert from cycle n+1 if reset/toggle-enable bits 6 and 7 are 1. A write to the set-enable register loads data bits 7:6 into these flip-flops, and that write takes precedence over a toggle in the same cycle.
- R4: `se_rd` returns the set-enable bits 5:0 in bits 5:0 and the toggle flip-flop state in bits 7:6.
- R5: Match flag i (`cm_flag[i]`) reads 1 from the cycle after a match on compare value i and stays set until `flag_clr[i]` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R6: `irq_req[2:0]` follows `cm_flag` one cycle later, so a match reaches the request two cycles after it occurs. `irq_req[3]` and `irq_req[4]` equal the byte and full overflow flags in the same cycle.
- R7: A match is taken only in the first cycle in which the timer equals the compare value. Holding the timer at that value does not retrigger. Directly after reset, no match is taken until the timer has held a different value.
- R8: If compare values 0 and 1 match in the same cycle, a bit that both enable registers select ends up 0.
- R9: `ov_flag[0]` reads 1 from the cycle after the timer input's low byte goes from 0xFF to 0x00. `ov_flag[1]` reads 1 from the cycle after the whole timer goes from all ones to zero. Both are sticky and are cleared by `flag_clr[3]` and `flag_clr[4]`.
- R10: While reset is held and in the cycle after it, the outputs, the toggle flip-flops, all flags, all requests and both enable registers read 0.
- R11: A write with `wr_addr` 0, 1 or 2 loads that compare value. Address 3 loads the set-enable register and address 4 loads the reset/toggle-enable register. Other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr | input | TW | Current timer value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0-2 compare, 3 set-enable, 4 reset/toggle-enable) |
| wr_data | input | TW | Write data |
| flag_clr | input | 5 | Clear pulses: bits 2:0 match flags, bit 3 byte overflow, bit 4 full overflow |
| port_out | output | 8 | Output port: bits 5:0 set/reset, bits 7:6 toggle |
| se_rd | output | 8 | Set-enable readback with toggle state in bits 7:6 |
| cm_flag | output | 3 | Sticky match flags |
| ov_flag | output | 2 | Sticky overflow flags (bit 0 byte, bit 1 full) |
| irq_req | output | 5 | Interrupt requests: match 2:0, byte overflow 3, full overflow 4 |

## Verification
The bench builds the unit with a 10-bit timer and keeps the default port split of six set/reset bits and two toggle bits. With a 10-bit timer, a complete sweep of the timer takes about a thousand cycles, so every timer value is visited under several enable and compare configurations. Both the byte wrap (255 to 256) and the full wrap (1023 to 0) fall inside a single sweep. Because each sweep covers the whole timer range, coincident compare values, a timer held at a compare value, and flag clears that collide with new matches are all reached deliberately.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int NCMP = 3;            // compare channels
  localparam int AW   = 3;            // register address width
  localparam logic [AW-1:0] ADDR_SE  = 3'd3;
  localparam logic [AW-1:0] ADDR_RTE = 3'd4;
  localparam int NOV  = 2;            // overflow flags: byte, full
  localparam int NFLG = NCMP + NOV;
endpackage

// File: rtl/cmp_out_match.sv
module cmp_out_match
  import cmp_out_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  output logic [NCMP-1:0] hit
);
  logic [NCMP-1:0] eq;
  logic [NCMP-1:0] eq_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    logic [TW-1:0] cmp_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q <= '0;
      end else if (wr_en && (wr_addr == AW'(i))) begin
        cmp_q <= wr_data;
      end
    end

    assign eq[i] = (tmr == cmp_q);
  end

  // previous equality; reset high so a timer parked on the value after
  // reset does not fire
  always_ff @(posedge clk) begin
    if (rst) eq_q <= '1;
    else     eq_q <= eq;
  end

  assign hit = eq & ~eq_q;
endmodule

// File: rtl/cmp_out_wrap.sv
module cmp_out_wrap
  import cmp_out_pkg::*;
#(
  parameter int TW = 16,
  parameter int BW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TW-1:0]  tmr,
  output logic [NOV-1:0] wrap
);
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) tmr_q <= '0;
    else     tmr_q <= tmr;
  end

  assign wrap[0] = (tmr[BW-1:0] == '0) && (tmr_q[BW-1:0] == '1);
  assign wrap[1] = (tmr == '0) && (tmr_q == '1);
endmodule

// File: rtl/cmp_out_port.sv
module cmp_out_port #(
  parameter int NSR = 6,
  parameter int NTG = 2,
  localparam int W  = NSR + NTG
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit_set,
  input  logic           hit_rst,
  input  logic           se_wr,
  input  logic           rte_wr,
  input  logic [W-1:0]   wdata,
  output logic [NSR-1:0] se_en,
  output logic [W-1:0]   rte_en,
  output logic [W-1:0]   port,
  output logic [W-1:0]   se_rd
);
  logic [NSR-1:0] sr_q, sr_n;
  logic [NTG-1:0] tg_q, tg_n;

  always_comb begin
    sr_n = sr_q;
    if (hit_set) sr_n = sr_n | se_en;
    if (hit_rst) sr_n = sr_n & ~rte_en[NSR-1:0];   // reset applied last: wins
  end

  always_comb begin
    tg_n = tg_q;
    if (se_wr)        tg_n = wdata[W-1:NSR];
    else if (hit_rst) tg_n = tg_q ^ rte_en[W-1:NSR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      se_en  <= '0;
      rte_en <= '0;
      sr_q   <= '0;
      tg_q   <= '0;
    end else begin
      if (se_wr)  se_en  <= wdata[NSR-1:0];
      if (rte_wr) rte_en <= wdata;
      sr_q <= sr_n;
      tg_q <= tg_n;
    end
  end

  assign port  = {tg_q, sr_q};
  assign se_rd = {tg_q, se_en};
endmodule

// File: rtl/cmp_out_flags.sv
module cmp_out_flags
  import cmp_out_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NCMP-1:0] hit,
  input  logic [NOV-1:0]  wrap,
  input  logic [NFLG-1:0] clr,
  output logic [NCMP-1:0] cm_flag,
  output logic [NOV-1:0]  ov_flag,
  output logic [NFLG-1:0] irq_req
);
  logic [NCMP-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_flag <= '0;
      ov_flag <= '0;
      req_q   <= '0;
    end else begin
      cm_flag <= (cm_flag & ~clr[NCMP-1:0]) | hit;
      ov_flag <= (ov_flag & ~clr[NFLG-1:NCMP]) | wrap;
      req_q   <= cm_flag;   // extra stage: match requests lag their flags
    end
  end

  assign irq_req = {ov_flag, req_q};
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int TW  = 16,
  parameter int NSR = 6,
  parameter int NTG = 2,
  localparam int W  = NSR + NTG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   tmr,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [TW-1:0]   wr_data,
  input  logic [NFLG-1:0] flag_clr,
  output logic [W-1:0]    port_out,
  output logic [W-1:0]    se_rd,
  output logic [NCMP-1:0] cm_flag,
  output logic [NOV-1:0]  ov_flag,
  output logic [NFLG-1:0] irq_req
);
  logic [NCMP-1:0] cm_hit;
  logic [NOV-1:0]  wrap;
  logic [NSR-1:0]  se_en;
  logic [W-1:0]    rte_en;
  logic            se_wr, rte_wr;

  assign se_wr  = wr_en && (wr_addr == ADDR_SE);
  assign rte_wr = wr_en && (wr_addr == ADDR_RTE);

  cmp_out_match #(.TW(TW)) u_match (
    .clk(clk), .rst(rst), .tmr(tmr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit(cm_hit)
  );

  cmp_out_wrap #(.TW(TW), .BW(8)) u_wrap (
    .clk(clk), .rst(rst), .tmr(tmr), .wrap(wrap)
  );

  cmp_out_port #(.NSR(NSR), .NTG(NTG)) u_port (
    .clk(clk), .rst(rst), .hit_set(cm_hit[0]), .hit_rst(cm_hit[1]),
    .se_wr(se_wr), .rte_wr(rte_wr), .wdata(wr_data[W-1:0]),
    .se_en(se_en), .rte_en(rte_en), .port(port_out), .se_rd(se_rd)
  );

  cmp_out_flags u_flags (
    .clk(clk), .rst(rst), .hit(cm_hit), .wrap(wrap), .clr(flag_clr),
    .cm_flag(cm_flag), .ov_flag(ov_flag), .irq_req(irq_req)
  );
endmodule

// File: rtl/cmp_out_unit_chk.sv
module cmp_out_unit_chk #(
  parameter int NSR = 6,
  parameter int NTG = 2,
  localparam int W  = NSR + NTG
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     hit,
  input logic [W-1:0]   port,
  input logic [NSR-1:0] se_en,
  input logic [W-1:0]   rte_en,
  input logic           se_wr,
  input logic [2:0]     cm_flag,
  input logic [4:0]     irq_req
);
  a_r1_set: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && !hit[1]) |=> ((port[NSR-1:0] & $past(se_en)) == $past(se_en)));

  a_r2_reset: assert property (@(posedge clk) disable iff (rst)
    hit[1] |=> ((port[NSR-1:0] & $past(rte_en[NSR-1:0])) == '0));

  a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
    (hit[1] && !se_wr) |=>
      (port[W-1:NSR] == ($past(port[W-1:NSR]) ^ $past(rte_en[W-1:NSR]))));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((cm_flag & $past(hit)) == $past(hit)));

  a_r6_req_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(cm_flag[0]) |=> irq_req[0]);

  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((hit & $past(hit)) == '0));

  a_r10_reset: assert property (@(posedge clk)
    $past(rst) |-> (port == '0 && cm_flag == '0 && irq_req == '0));
endmodule

bind cmp_out_unit cmp_out_unit_chk #(.NSR(NSR), .NTG(NTG)) u_chk (
  .clk(clk), .rst(rst), .hit(cm_hit), .port(port_out), .se_en(se_en),
  .rte_en(rte_en), .se_wr(se_wr), .cm_flag(cm_flag), .irq_req(irq_req)
);

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;
  localparam int TW = 10;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tmr = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [4:0]    flag_clr = '0;
  logic [7:0]    port_out, se_rd;
  logic [2:0]    cm_flag;
  logic [1:0]    ov_flag;
  logic [4:0]    irq_req;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [TW-1:0] m_cm [3];
  logic [5:0] m_se, m_sr;
  logic [7:0] m_rte;
  logic [1:0] m_tg, m_ovf;
  logic [2:0] m_eqp, m_cmf, m_req;
  logic [TW-1:0] m_tq;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_unit #(.TW(TW), .NSR(6), .NTG(2)) u_dut (
    .clk(clk), .rst(rst), .tmr(tmr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_clr(flag_clr), .port_out(port_out),
    .se_rd(se_rd), .cm_flag(cm_flag), .ov_flag(ov_flag), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(port_out[5:0] == m_sr, "R1 R2 port[5:0]", port_out[5:0], m_sr);
    chk(port_out[7:6] == m_tg, "R3 port[7:6]", port_out[7:6], m_tg);
    chk(se_rd == {m_tg, m_se}, "R4 se_rd", se_rd, {m_tg, m_se});
    chk(cm_flag == m_cmf, "R5 cm_flag", cm_flag, m_cmf);
    chk(irq_req == {m_ovf, m_req}, "R6 irq_req", irq_req, {m_ovf, m_req});
    chk(ov_flag == m_ovf, "R9 ov_flag", ov_flag, m_ovf);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_cm[i] = '0;
    m_se = '0; m_sr = '0; m_rte = '0; m_tg = '0; m_ovf = '0;
    m_eqp = '1; m_cmf = '0; m_req = '0; m_tq = '0;
  endtask

  // advance one clock, updating the model from the requirements
  task automatic tick();
    logic [2:0] eq, h;
    logic [5:0] sr_n;
    logic [1:0] tg_n, wr_n;
    eq[0] = (tmr == m_cm[0]);
    eq[1] = (tmr == m_cm[1]);
    eq[2] = (tmr == m_cm[2]);
    h = eq & ~m_eqp;
    wr_n[0] = (tmr[7:0] == 8'h00) && (m_tq[7:0] == 8'hFF);
    wr_n[1] = (tmr == '0) && (m_tq == '1);
    sr_n = m_sr;
    if (h[0]) sr_n = sr_n | m_se;
    if (h[1]) sr_n = sr_n & ~m_rte[5:0];
    tg_n = m_tg;
    if (wr_en && wr_addr == 3'd3) tg_n = wr_data[7:6];
    else if (h[1]) tg_n = m_tg ^ m_rte[7:6];
    @(posedge clk);
    #1;
    m_req = m_cmf;
    m_cmf = (m_cmf & ~flag_clr[2:0]) | h;
    m_ovf = (m_ovf & ~flag_clr[4:3]) | wr_n;
    m_sr = sr_n; m_tg = tg_n; m_eqp = eq; m_tq = tmr;
    if (wr_en) begin
      case (wr_addr)
        3'd0, 3'd1, 3'd2: m_cm[wr_addr] = wr_data;
        3'd3: m_se = wr_data[5:0];
        3'd4: m_rte = wr_data[7:0];
        default: ;
      endcase
    end
    wr_en = 1'b0;
    flag_clr = '0;
    compare_all();
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [TW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic sweep(input int lo, input int hi);
    for (int t = lo; t <= hi; t++) begin
      tmr = TW'(t);
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(port_out == 8'h00, "R10 port", port_out, 0);
    chk({cm_flag, ov_flag, irq_req} == '0, "R10 flags", {cm_flag, ov_flag, irq_req}, 0);
    chk(se_rd == 8'h00, "R10 se_rd", se_rd, 0);
    rst = 1'b0;
    // R7: timer parked at 0 equal to reset compare values: no match
    tick(); tick();
    chk(cm_flag == 3'b000, "R7 no match after reset", cm_flag, 0);

    // config A: R11 register map, full sweep with wraps
    write_reg(3'd0, 10'd100);
    write_reg(3'd1, 10'd200);
    write_reg(3'd2, 10'd300);
    write_reg(3'd3, 10'h0BF);       // set all six, preset toggles to 2'b10
    write_reg(3'd4, 10'h0C5);       // reset bits 0 and 2, toggle both
    chk(se_rd == 8'hBF, "R4 R11 readback", se_rd, 8'hBF);
    sweep(1, 1023);
    sweep(0, 3);
    chk(ov_flag == 2'b11, "R9 both wraps seen", ov_flag, 2'b11);
    chk(port_out == 8'h7A, "R1 R2 R3 after sweep", port_out, 8'h7A);
    flag_clr = 5'h1F; tick();
    chk({cm_flag, ov_flag} == '0, "R5 R9 clear", {cm_flag, ov_flag}, 0);

    // R11: unmapped address changes nothing
    write_reg(3'd7, 10'h3FF);
    write_reg(3'd5, 10'h000);
    chk(se_rd == 8'h7F, "R11 unmapped write", se_rd, 8'h7F);

    // config B: R8 coincident matches
    write_reg(3'd0, 10'd50);
    write_reg(3'd1, 10'd50);
    write_reg(3'd3, 10'h00F);
    write_reg(3'd4, 10'h03C);
    sweep(4, 60);
    chk(port_out[3:0] == 4'b0011, "R8 reset wins", port_out[3:0], 4'b0011);

    // config C: R7 hold timer on compare 1, toggles flip once
    write_reg(3'd1, 10'd500);
    write_reg(3'd4, 10'h0C0);
    sweep(490, 500);
    for (int k = 0; k < 6; k++) tick();
    chk(port_out[7:6] == 2'b11, "R7 single toggle while held", port_out[7:6], 2'b11);

    // R5 set wins over clear in the same cycle; R6 request lag
    flag_clr = 5'h1F; tick();
    sweep(501, 505);
    tmr = 10'd50; flag_clr = 5'h01; tick();
    chk(cm_flag[0] == 1'b1, "R5 set beats clear", cm_flag[0], 1);
    chk(irq_req[0] == 1'b0, "R6 request not yet", irq_req[0], 0);
    tick();
    chk(irq_req[0] == 1'b1, "R6 request one cycle later", irq_req[0], 1);

    // R3: write to set-enable overrides a toggle in the same cycle
    sweep(51, 499);
    tmr = 10'd500; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 10'h040; tick();
    chk(port_out[7:6] == 2'b01, "R3 write beats toggle", port_out[7:6], 2'b01);
    sweep(501, 1023);
    sweep(0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule